// File: doc/BRIEF.md
# ISA Instrument-Bus Card Address Decoder with Shared-Interrupt Re-Arm

This block is the bus-side glue of an 8-bit ISA card that carries an eight-register instrument-bus controller and an optional time-of-day clock chip. It watches the 16-bit I/O address, the read and write strobes and AEN. From these it produces the chip selects, the read and write strobes and a 3-bit register index for the controller, a separate select for the clock chip, and an output enable for the card's data bus buffer. The controller's registers are spaced 0x400 apart: the high address bits choose the register, and a 2-bit board switch lets up to four cards share one system.

The block also manages a shared interrupt line. A rising edge on the controller's interrupt output sets a pending flag, which drives one of eight ISA IRQ lines while interrupts are enabled. The flag holds until host software writes any value to the re-arm port of that line, at 0x2F0 plus the IRQ number. An edge that arrives while the flag is already set is kept, and it raises the line again right after the re-arm. The decode paths are combinational. The pending flag is registered on the system clock.

Top module: `isa_ibus_decode`

## Requirements
- R1: The controller select `ctl_cs_n` is low exactly when all of these hold: AEN is low, IOR or IOW is active (low), A9..A0 equal 0x2E1, A14..A13 equal `board_sel`, and A15 is 0.
- R2: `reg_sel` equals A12..A10. Controller register n therefore sits at base + n*0x400.
- R3: If A14..A13 differ from `board_sel`, neither chip select is asserted and the data bus is not enabled.
- R4: When A15 is 1 and the other fields match, `clk_cs_n` goes low and `ctl_cs_n` stays high. The two selects are never low together.
- R5: While AEN is high, no select, strobe or output enable is asserted, and a write to the re-arm port has no effect on the IRQ lines.
- R6: `data_oe` is high only while IOR is active with a valid controller or clock-chip decode. It is never high during IOW.
- R7: `ctl_rd_n` and `ctl_wr_n` follow IOR and IOW, qualified by the controller decode. A value written at register index 3 (0x55 or 0xAA) reads back unchanged, and a write to a different index does not change it.
- R8: A rising edge of `ctl_int` sets the pending flag on the next clock. While the flag is set and `irq_en` is high, `isa_irq` is one-hot with bit `irq_sel` set. A level that stays high produces no new interrupt.
- R9: With `irq_en` low, `isa_irq` is all zero but the pending flag is kept. Raising `irq_en` drives the line at once.
- R10: A write of any data to address 0x2F0 + `irq_sel` clears the pending flag on the next clock. A write to any other port in 0x2F0..0x2F7 leaves the line unchanged.
- R11: A `ctl_int` edge that arrives while the flag is set is not lost. After the re-arm write the line drops for one cycle and then returns.
- R12: A clock edge with `rst_n` low clears the pending flag and any held edge, leaving `isa_irq` all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | ISA I/O address A15..A0 |
| aen | input | 1 | DMA address enable; high means the cycle is not for I/O slaves |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| board_sel | input | 2 | Board switch compared with A14..A13 |
| irq_sel | input | 3 | Selected ISA IRQ number, 0..7 |
| irq_en | input | 1 | Interrupt drive enable |
| ctl_int | input | 1 | Interrupt output of the bus controller |
| ctl_cs_n | output | 1 | Controller chip select, active low |
| ctl_rd_n | output | 1 | Controller read strobe, active low |
| ctl_wr_n | output | 1 | Controller write strobe, active low |
| reg_sel | output | 3 | Controller register index |
| clk_cs_n | output | 1 | Clock-chip select, active low |
| data_oe | output | 1 | Card data bus drive enable |
| isa_irq | output | 8 | ISA IRQ lines 0..7, active high |

## Verification
The bench sweeps all eight register indexes and probes each partial mismatch: wrong low bits, wrong board field, A15 set, and AEN high. A decoder that drops one field, or that ignores AEN, would assert a select that the bench sees as a wrong bus value or chip select. Wrong and masked (AEN high) re-arm ports are written while an interrupt is pending. A decoder that matched only the port range would release the line too early. An edge is raised while the flag is already set. A design that loses it would leave the line low after the re-arm, while one that never clears would show no one-cycle gap. The bench also toggles `irq_en` and `irq_sel` while an interrupt is pending, and resets with `ctl_int` held high, to expose a flag cleared by masking or an edge falsely seen after reset.

// File: rtl/isa_ibus_pkg.sv
// Package: fixed address constants shared by the decoder and its checker.
// Assumes an I/O space that is fully decoded to 16 bits.
package isa_ibus_pkg;
    // Low address pattern that every controller or clock-chip access must carry
    localparam int CTL_LOW_MATCH = 'h2E1;
    // First re-arm port; the port of IRQ n is this value plus n
    localparam int REARM_BASE    = 'h2F0;
endpackage

// File: rtl/io_addr_decode.sv
// Module: io_addr_decode
// Combinational decode of the ISA I/O address into controller strobes, clock-chip
// select, bus output enable and the re-arm port hit. Field layout, LSB first:
// LOW_W fixed-match bits, RSEL_W register bits, BOARD_W board bits, one chip bit.
// Assumes strobes are active low and AEN high marks a DMA cycle.
module io_addr_decode
    import isa_ibus_pkg::*;
#(
    parameter int LOW_W   = 10,
    parameter int RSEL_W  = 3,
    parameter int BOARD_W = 2,
    parameter int IRQ_W   = 3,
    localparam int BOARD_LSB = LOW_W + RSEL_W,
    localparam int CHIP_BIT  = BOARD_LSB + BOARD_W,
    localparam int ADDR_W    = CHIP_BIT + 1
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               aen,
    input  logic               ior_n,
    input  logic               iow_n,
    input  logic [BOARD_W-1:0] board_sel,
    input  logic [IRQ_W-1:0]   irq_sel,
    output logic               ctl_cs_n,
    output logic               ctl_rd_n,
    output logic               ctl_wr_n,
    output logic [RSEL_W-1:0]  reg_sel,
    output logic               clk_cs_n,
    output logic               data_oe,
    output logic               rearm_hit
);
    logic low_ok, board_ok, card_ok, ctl_hit, chip_hit, any_strobe;
    logic [ADDR_W-1:0] rearm_addr;

    // Field matches qualified by AEN so DMA cycles never reach the card
    always_comb begin
        low_ok   = (addr[LOW_W-1:0] == LOW_W'(CTL_LOW_MATCH));
        board_ok = (addr[BOARD_LSB +: BOARD_W] == board_sel);
        card_ok  = !aen && low_ok && board_ok;
        ctl_hit  = card_ok && !addr[CHIP_BIT];
        chip_hit = card_ok && addr[CHIP_BIT];
    end

    // Chip selects and controller strobes
    always_comb begin
        any_strobe = !ior_n || !iow_n;
        ctl_cs_n   = !(ctl_hit && any_strobe);
        ctl_rd_n   = !(ctl_hit && !ior_n);
        ctl_wr_n   = !(ctl_hit && !iow_n);
        clk_cs_n   = !(chip_hit && any_strobe);
        reg_sel    = addr[LOW_W +: RSEL_W];
        data_oe    = !ior_n && (ctl_hit || chip_hit);
    end

    // Re-arm port: a write to the single port that belongs to the selected IRQ
    always_comb begin
        rearm_addr = ADDR_W'(REARM_BASE) + ADDR_W'(irq_sel);
        rearm_hit  = !aen && !iow_n && (addr == rearm_addr);
    end
endmodule

// File: rtl/irq_rearm_latch.sv
// Module: irq_rearm_latch
// Holds the interrupt-pending flag. A rising edge of the controller interrupt
// sets it; the first clock of a re-arm write clears it. An edge seen while the
// flag is set is parked and re-sets the flag on the clock after the re-arm.
// Assumes ctl_int and rearm_hit are already synchronous to clk.
module irq_rearm_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_int,
    input  logic rearm_hit,
    output logic pending
);
    logic int_q, rearm_q, held, int_rise, rearm_pulse;

    // Previous interrupt level for edge detection; tracks through reset on purpose
    always_ff @(posedge clk) int_q <= ctl_int;

    // Previous re-arm state so a long write strobe clears only once
    always_ff @(posedge clk) begin
        if (!rst_n) rearm_q <= 1'b0;
        else        rearm_q <= rearm_hit;
    end

    always_comb begin
        int_rise    = ctl_int && !int_q;
        rearm_pulse = rearm_hit && !rearm_q;
    end

    // Pending flag and parked edge update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            held    <= 1'b0;
        end else if (rearm_pulse) begin
            pending <= 1'b0;
            held    <= held || int_rise;
        end else if (int_rise) begin
            if (pending) held <= 1'b1;
            else begin
                pending <= 1'b1;
                held    <= 1'b0;
            end
        end else if (held && !pending) begin
            pending <= 1'b1;
            held    <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_line_drive.sv
// Module: irq_line_drive
// Steers the pending flag onto one of NUM_IRQ ISA lines chosen by irq_sel.
// Assumes irq_sel stays below NUM_IRQ; out-of-range values drive nothing.
module irq_line_drive #(
    parameter int NUM_IRQ = 8,
    localparam int IRQ_W  = $clog2(NUM_IRQ)
) (
    input  logic               pending,
    input  logic               irq_en,
    input  logic [IRQ_W-1:0]   irq_sel,
    output logic [NUM_IRQ-1:0] isa_irq
);
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        // One line per IRQ number, active only when selected and enabled
        assign isa_irq[i] = pending && irq_en && (irq_sel == IRQ_W'(i));
    end
endmodule

// File: rtl/isa_ibus_decode.sv
// Module: isa_ibus_decode (top)
// Bus glue for an ISA instrument-bus card: address decode for an eight-register
// controller and a clock chip, and a shared IRQ held until a re-arm port write.
// Assumes a single system clock to which ctl_int and the ISA strobes are synchronous.
module isa_ibus_decode #(
    parameter int LOW_W   = 10,
    parameter int RSEL_W  = 3,
    parameter int BOARD_W = 2,
    parameter int NUM_IRQ = 8,
    localparam int IRQ_W  = $clog2(NUM_IRQ),
    localparam int ADDR_W = LOW_W + RSEL_W + BOARD_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               aen,
    input  logic               ior_n,
    input  logic               iow_n,
    input  logic [BOARD_W-1:0] board_sel,
    input  logic [IRQ_W-1:0]   irq_sel,
    input  logic               irq_en,
    input  logic               ctl_int,
    output logic               ctl_cs_n,
    output logic               ctl_rd_n,
    output logic               ctl_wr_n,
    output logic [RSEL_W-1:0]  reg_sel,
    output logic               clk_cs_n,
    output logic               data_oe,
    output logic [NUM_IRQ-1:0] isa_irq
);
    logic rearm_hit, pending;

    io_addr_decode #(
        .LOW_W(LOW_W), .RSEL_W(RSEL_W), .BOARD_W(BOARD_W), .IRQ_W(IRQ_W)
    ) u_decode (
        .addr(addr), .aen(aen), .ior_n(ior_n), .iow_n(iow_n),
        .board_sel(board_sel), .irq_sel(irq_sel),
        .ctl_cs_n(ctl_cs_n), .ctl_rd_n(ctl_rd_n), .ctl_wr_n(ctl_wr_n),
        .reg_sel(reg_sel), .clk_cs_n(clk_cs_n), .data_oe(data_oe),
        .rearm_hit(rearm_hit)
    );

    irq_rearm_latch u_latch (
        .clk(clk), .rst_n(rst_n), .ctl_int(ctl_int),
        .rearm_hit(rearm_hit), .pending(pending)
    );

    irq_line_drive #(.NUM_IRQ(NUM_IRQ)) u_drive (
        .pending(pending), .irq_en(irq_en), .irq_sel(irq_sel), .isa_irq(isa_irq)
    );
endmodule

// File: rtl/isa_ibus_decode_chk.sv
// Module: isa_ibus_decode_chk
// Port-level properties of isa_ibus_decode, attached with bind below.
module isa_ibus_decode_chk
    import isa_ibus_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int NUM_IRQ = 8,
    localparam int IRQ_W  = $clog2(NUM_IRQ)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  addr,
    input logic               aen,
    input logic               ior_n,
    input logic               iow_n,
    input logic [IRQ_W-1:0]   irq_sel,
    input logic               irq_en,
    input logic               ctl_int,
    input logic               ctl_cs_n,
    input logic               clk_cs_n,
    input logic               data_oe,
    input logic [NUM_IRQ-1:0] isa_irq
);
    // R8: at most one IRQ line driven
    a_r8_irq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isa_irq));

    // R5: DMA cycles select nothing
    a_r5_aen_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        aen |-> (ctl_cs_n && clk_cs_n && !data_oe));

    // R4: selects mutually exclusive
    a_r4_cs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ctl_cs_n && !clk_cs_n));

    // R6: bus driven only during a read
    a_r6_oe_needs_ior: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !ior_n);

    // R8: a controller edge with no write in progress shows on the line next cycle
    a_r8_irq_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctl_int) && iow_n) |=> (!irq_en || (isa_irq != '0)));

    // R10: start of a matching re-arm write drops the line next cycle
    a_r10_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(iow_n) && !aen && !$rose(ctl_int) &&
         (addr == ADDR_W'(REARM_BASE) + ADDR_W'(irq_sel))) |=> (isa_irq == '0));

    // R12: reset leaves all lines idle
    a_r12_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (isa_irq == '0));
endmodule

bind isa_ibus_decode isa_ibus_decode_chk #(.ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .aen(aen), .ior_n(ior_n),
    .iow_n(iow_n), .irq_sel(irq_sel), .irq_en(irq_en), .ctl_int(ctl_int),
    .ctl_cs_n(ctl_cs_n), .clk_cs_n(clk_cs_n), .data_oe(data_oe),
    .isa_irq(isa_irq)
);

// File: tb/isa_ibus_decode_bench.sv
// Scoreboard bench: driver tasks queue expected items, a monitor compares them.
module isa_ibus_decode_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        aen = 1'b0, ior_n = 1'b1, iow_n = 1'b1;
    logic [1:0]  board_sel = 2'b01;
    logic [2:0]  irq_sel = 3'd5;
    logic        irq_en = 1'b1, ctl_int = 1'b0;
    logic        ctl_cs_n, ctl_rd_n, ctl_wr_n, clk_cs_n, data_oe;
    logic [2:0]  reg_sel;
    logic [7:0]  isa_irq;
    logic [7:0]  host_wd = 8'h00;
    logic [7:0]  mregs [8];
    logic [7:0]  bus;

    always #5 clk = ~clk;

    isa_ibus_decode u_isa_ibus_decode (
        .clk(clk), .rst_n(rst_n), .addr(addr), .aen(aen), .ior_n(ior_n),
        .iow_n(iow_n), .board_sel(board_sel), .irq_sel(irq_sel), .irq_en(irq_en),
        .ctl_int(ctl_int), .ctl_cs_n(ctl_cs_n), .ctl_rd_n(ctl_rd_n),
        .ctl_wr_n(ctl_wr_n), .reg_sel(reg_sel), .clk_cs_n(clk_cs_n),
        .data_oe(data_oe), .isa_irq(isa_irq)
    );

    // Controller model: eight byte registers, clock chip reads 0xEE, pull-ups give 0xFF
    initial for (int i = 0; i < 8; i++) mregs[i] = 8'h00;
    always @(negedge ctl_wr_n) mregs[reg_sel] = host_wd;
    assign bus = data_oe ? (!ctl_rd_n ? mregs[reg_sel] : 8'hEE) : 8'hFF;

    typedef enum {F_CTLCS, F_CLKCS, F_RSEL, F_OE, F_IRQ, F_BUS, F_RD, F_WR} fld_e;
    typedef struct {fld_e f; int exp; string req;} item_t;
    item_t sbq[$];
    event  smp_ev;
    int    checks = 0, fails = 0;
    bit    done = 1'b0;

    function automatic int observe(fld_e f);
        case (f)
            F_CTLCS: return int'(ctl_cs_n);
            F_CLKCS: return int'(clk_cs_n);
            F_RSEL:  return int'(reg_sel);
            F_OE:    return int'(data_oe);
            F_IRQ:   return int'(isa_irq);
            F_BUS:   return int'(bus);
            F_RD:    return int'(ctl_rd_n);
            default: return int'(ctl_wr_n);
        endcase
    endfunction

    // Monitor: pops expected items and compares with what the design shows
    initial forever begin
        @(smp_ev);
        while (sbq.size() > 0) begin
            item_t it;
            int    act;
            it  = sbq.pop_front();
            act = observe(it.f);
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s %s actual=0x%0h expected=0x%0h",
                         it.req, it.f.name(), act, it.exp);
            end
        end
    end

    task automatic push(fld_e f, int e, string r);
        sbq.push_back('{f, e, r});
    endtask

    task automatic sample();
        ->smp_ev;
        #1;
    endtask

    task automatic io(logic [15:0] a, bit wr, logic a_en, logic [7:0] wd);
        addr = a; aen = a_en; host_wd = wd;
        #1;
        if (wr) iow_n = 1'b0; else ior_n = 1'b0;
        #1;
    endtask

    task automatic io_end();
        ior_n = 1'b1; iow_n = 1'b1;
        #1;
    endtask

    // Writes to a port, holding the strobe across one rising clock edge
    task automatic port_write(logic [15:0] a, logic a_en);
        @(negedge clk);
        addr = a; aen = a_en; iow_n = 1'b0;
        @(negedge clk);
        iow_n = 1'b1; aen = 1'b0;
    endtask

    initial begin
        // Reset state (R12)
        repeat (3) @(negedge clk);
        push(F_IRQ, 0, "R12"); push(F_CTLCS, 1, "R12"); push(F_OE, 0, "R12");
        sample();
        rst_n = 1'b1;
        @(negedge clk);

        // Basic controller read at board 1 base 0x22E1 (R1)
        io(16'h22E1, 0, 0, 0);
        push(F_CTLCS, 0, "R1"); push(F_RD, 0, "R1"); push(F_OE, 1, "R1");
        push(F_RSEL, 0, "R2"); push(F_CLKCS, 1, "R1");
        sample(); io_end();
        // Address valid but no strobe (R1)
        push(F_CTLCS, 1, "R1"); sample();

        // All eight registers 0x400 apart (R2)
        for (int i = 0; i < 8; i++) begin
            io(16'h22E1 + 16'(i * 'h400), 0, 0, 0);
            push(F_RSEL, i, "R2"); push(F_CTLCS, 0, "R2");
            sample(); io_end();
        end

        // Index 3 write/readback with both patterns, plus isolation (R7)
        io(16'h2EE1, 1, 0, 8'h55);
        push(F_WR, 0, "R7"); push(F_OE, 0, "R6"); push(F_RD, 1, "R7");
        sample(); io_end();
        io(16'h2EE1, 0, 0, 0); push(F_BUS, 'h55, "R7"); sample(); io_end();
        io(16'h2EE1, 1, 0, 8'hAA); io_end();
        io(16'h2AE1, 1, 0, 8'h13); io_end();
        io(16'h2EE1, 0, 0, 0); push(F_BUS, 'hAA, "R7"); sample(); io_end();
        io(16'h2AE1, 0, 0, 0); push(F_BUS, 'h13, "R7"); sample(); io_end();

        // Board field mismatch (R3)
        io(16'h42E1, 0, 0, 0);
        push(F_CTLCS, 1, "R3"); push(F_CLKCS, 1, "R3"); push(F_OE, 0, "R3");
        push(F_BUS, 'hFF, "R3");
        sample(); io_end();
        // Low field mismatch (R1)
        io(16'h22E2, 0, 0, 0); push(F_CTLCS, 1, "R1"); push(F_OE, 0, "R1");
        sample(); io_end();

        // Clock chip at A15 set (R4)
        io(16'hA2E1, 0, 0, 0);
        push(F_CLKCS, 0, "R4"); push(F_CTLCS, 1, "R4"); push(F_BUS, 'hEE, "R4");
        sample(); io_end();

        // DMA cycle ignored (R5)
        io(16'h22E1, 0, 1, 0);
        push(F_CTLCS, 1, "R5"); push(F_OE, 0, "R5"); push(F_RD, 1, "R5");
        sample(); io_end();
        io(16'h2EE1, 1, 1, 8'h77); io_end(); aen = 1'b0;
        io(16'h2EE1, 0, 0, 0); push(F_BUS, 'hAA, "R5"); sample(); io_end();

        // Interrupt raise on IRQ 5 (R8)
        addr = 16'h0000;
        @(negedge clk); ctl_int = 1'b1;
        @(negedge clk); push(F_IRQ, 'h20, "R8"); sample();
        // Second edge while pending is parked (R11)
        @(negedge clk); ctl_int = 1'b0;
        @(negedge clk); ctl_int = 1'b1;
        @(negedge clk); push(F_IRQ, 'h20, "R11"); sample();

        // Wrong port and DMA-masked port leave the line (R10, R5)
        port_write(16'h02F3, 1'b0);
        @(negedge clk); push(F_IRQ, 'h20, "R10"); sample();
        port_write(16'h02F5, 1'b1);
        @(negedge clk); push(F_IRQ, 'h20, "R5"); sample();

        // Matching re-arm: one-cycle gap, then the parked edge returns (R11)
        @(negedge clk);
        addr = 16'h02F5; iow_n = 1'b0;
        @(negedge clk); push(F_IRQ, 0, "R11"); sample(); iow_n = 1'b1;
        @(negedge clk); push(F_IRQ, 'h20, "R11"); sample();

        // Re-arm with nothing parked stays clear; held level gives nothing new (R10, R8)
        port_write(16'h02F5, 1'b0);
        push(F_IRQ, 0, "R10"); sample();
        repeat (2) @(negedge clk);
        push(F_IRQ, 0, "R8"); sample();

        // Masking keeps the flag (R9), line follows selection (R8)
        irq_en = 1'b0; ctl_int = 1'b0;
        @(negedge clk); ctl_int = 1'b1;
        @(negedge clk); push(F_IRQ, 0, "R9"); sample();
        irq_en = 1'b1; #1;
        push(F_IRQ, 'h20, "R9"); sample();
        irq_sel = 3'd2; #1;
        push(F_IRQ, 'h04, "R8"); sample();
        port_write(16'h02F2, 1'b0);
        push(F_IRQ, 0, "R10"); sample();

        // Reset clears a pending interrupt; held level is no edge afterwards (R12)
        ctl_int = 1'b0;
        @(negedge clk); ctl_int = 1'b1;
        @(negedge clk); push(F_IRQ, 'h04, "R8"); sample();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); push(F_IRQ, 0, "R12"); sample(); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        push(F_IRQ, 0, "R12"); sample();

        #5;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule